// File: doc/BRIEF.md
# Coherent Encoder Snapshot Reader

This block sits between a multi-axis encoder front end and a host that reads bytes over an 8-bit parallel bus. Each axis has a 24-bit position count and a 16-bit edge timestamp, 40 bits in all. Those 40 bits cannot cross the bus in one access. The block solves this with two register layers per axis.

The first layer is a holding register. It loads count and timestamp together whenever the encoder front end pulses that axis's latch strobe, so both values always describe the same edge. The second layer is a snapshot. It copies the holding register when the host reads the axis's least significant count byte, or when the host writes a dedicated control address, which freezes every axis at once. All other bytes of the axis are served from the snapshot, so a byte-by-byte read never mixes two edges.

The count bytes keep their original low addresses. The timestamp bytes occupy spare upper addresses, and a revision byte lets host software find out whether the timestamp bytes exist.

A two-state bus machine controls reads:
- ST_IDLE: waits for a request.
- ST_RDATA: presents one byte for exactly one cycle.
- Transitions: "accept" (ST_IDLE to ST_RDATA on a read request) and "retire" (ST_RDATA back to ST_IDLE, unconditionally).
- Writes are acted on only in ST_IDLE and never leave it.

Top module: `enc_snap_rd`

## Requirements
- R1: After reset, rd_vld is 0, rdata is 0x00, and every holding and snapshot register is zero.
- R2: A read request in ST_IDLE raises rd_vld on the next cycle for exactly one cycle, with the byte on rdata. A request made while rd_vld is high is dropped. rdata is 0x00 whenever rd_vld is low.
- R3: A latch strobe for axis a loads both that axis's count and timestamp, sampled in the same cycle, into its holding register.
- R4: A read of address 3a (the count's least significant byte for axis a, where a is 0 to 3) returns bits [7:0] of the holding register's count. In the same cycle it copies the whole holding register of axis a into that axis's snapshot.
- R5: Count bytes 1 and 2 sit at 3a+1 and 3a+2, and timestamp bytes 0 and 1 sit at 0x10+2a and 0x11+2a, all little-endian. They return snapshot contents and do not change on later latch strobes until the snapshot is refreshed.
- R6: Address 0x1F reads the revision byte, 0x02 by default.
- R7: A write to address 0x1E in ST_IDLE, with no read request in the same cycle, copies every axis's holding register into its snapshot.
- R8: A write to any address other than 0x1E has no effect on any later read.
- R9: Reads of addresses 0x0C–0x0F and 0x18–0x1E return 0x00.
- R10: A snapshot refresh caused by one axis's low-byte read leaves every other axis's snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_ld | input | NAX | Per-axis latch strobe from the encoder front end |
| enc_cnt | input | NAX*CNT_W | Live counts, axis 0 in the low bits |
| enc_ts | input | NAX*TS_W | Live edge timestamps, axis 0 in the low bits |
| rd_req | input | 1 | Byte read request |
| wr_req | input | 1 | Byte write request (data not used) |
| addr | input | ADDR_W | Byte address |
| rdata | output | 8 | Read byte, valid while rd_vld is high |
| rd_vld | output | 1 | Read data valid, one cycle per accepted read |

## Verification
The bench builds the block with its default values: four axes, a 24-bit count, a 16-bit timestamp and a 5-bit address. With these values every byte offset, the gap between the count and timestamp regions, the control address and the revision address all fall inside one 32-address sweep. Because the bench uses four axes, it can show an axis that was never frozen next to axes that were. Its two sets of input values give every byte of every axis a distinct pattern, so a stale byte or a byte from the wrong lane shows up as a mismatch.

// File: rtl/enc_snap_pkg.sv
package enc_snap_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } rd_state_e;
endpackage

// File: rtl/enc_addr_dec.sv
module enc_addr_dec #(
    parameter int NAX       = 4,
    parameter int CNT_BYTES = 3,
    parameter int TS_BYTES  = 2,
    parameter int ADDR_W    = 5,
    parameter int CNT_BASE  = 0,
    parameter int TS_BASE   = 16,
    parameter int REV_ADDR  = 31,
    parameter int AXW       = 2,
    parameter int BSW       = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_cnt,
    output logic              hit_ts,
    output logic              hit_rev,
    output logic              lo_byte,
    output logic [AXW-1:0]    ax,
    output logic [BSW-1:0]    bsel
);
    always_comb begin
        hit_cnt = 1'b0;
        hit_ts  = 1'b0;
        ax      = '0;
        bsel    = '0;
        for (int a = 0; a < NAX; a++) begin
            for (int b = 0; b < CNT_BYTES; b++) begin
                if (int'(addr) == CNT_BASE + a*CNT_BYTES + b) begin
                    hit_cnt = 1'b1;
                    ax      = AXW'(a);
                    bsel    = BSW'(b);
                end
            end
            for (int b = 0; b < TS_BYTES; b++) begin
                if (int'(addr) == TS_BASE + a*TS_BYTES + b) begin
                    hit_ts = 1'b1;
                    ax     = AXW'(a);
                    bsel   = BSW'(b);
                end
            end
        end
        hit_rev = (int'(addr) == REV_ADDR);
        lo_byte = hit_cnt && (bsel == '0);
    end
endmodule

// File: rtl/enc_axis_hold.sv
module enc_axis_hold #(
    parameter int CNT_W = 24,
    parameter int TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [TS_W-1:0]  ts_in,
    input  logic             frz,
    output logic [7:0]       hold_lo,
    output logic [CNT_W-1:0] snap_cnt,
    output logic [TS_W-1:0]  snap_ts
);
    logic [CNT_W-1:0] hold_cnt;
    logic [TS_W-1:0]  hold_ts;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            hold_ts  <= '0;
            snap_cnt <= '0;
            snap_ts  <= '0;
        end else begin
            if (ld) begin
                hold_cnt <= cnt_in;
                hold_ts  <= ts_in;
            end
            if (frz) begin
                snap_cnt <= hold_cnt;
                snap_ts  <= hold_ts;
            end
        end
    end

    assign hold_lo = hold_cnt[7:0];
endmodule

// File: rtl/enc_snap_rd.sv
module enc_snap_rd #(
    parameter int          NAX       = 4,
    parameter int          CNT_W     = 24,
    parameter int          TS_W      = 16,
    parameter int          ADDR_W    = 5,
    parameter int          CNT_BASE  = 0,
    parameter int          TS_BASE   = 16,
    parameter int          SNAP_ADDR = 30,
    parameter int          REV_ADDR  = 31,
    parameter logic [7:0]  REV       = 8'h02
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NAX-1:0]        enc_ld,
    input  logic [NAX*CNT_W-1:0]  enc_cnt,
    input  logic [NAX*TS_W-1:0]   enc_ts,
    input  logic                  rd_req,
    input  logic                  wr_req,
    input  logic [ADDR_W-1:0]     addr,
    output logic [7:0]            rdata,
    output logic                  rd_vld
);
    import enc_snap_pkg::*;

    localparam int CNT_BYTES = CNT_W / BYTE_W;
    localparam int TS_BYTES  = TS_W / BYTE_W;
    localparam int MAXB      = (CNT_BYTES > TS_BYTES) ? CNT_BYTES : TS_BYTES;
    localparam int AXW       = (NAX > 1) ? $clog2(NAX) : 1;
    localparam int BSW       = (MAXB > 1) ? $clog2(MAXB) : 1;

    rd_state_e state_q, state_d;

    logic           hit_cnt, hit_ts, hit_rev, lo_byte;
    logic [AXW-1:0] ax;
    logic [BSW-1:0] bsel;
    logic           accept, frz_all;
    logic [NAX-1:0] frz;
    logic [7:0]     rd_byte, data_q;

    logic [7:0]       hold_lo  [NAX];
    logic [CNT_W-1:0] snap_cnt [NAX];
    logic [TS_W-1:0]  snap_ts  [NAX];

    enc_addr_dec #(
        .NAX(NAX), .CNT_BYTES(CNT_BYTES), .TS_BYTES(TS_BYTES), .ADDR_W(ADDR_W),
        .CNT_BASE(CNT_BASE), .TS_BASE(TS_BASE), .REV_ADDR(REV_ADDR),
        .AXW(AXW), .BSW(BSW)
    ) u_dec (
        .addr(addr), .hit_cnt(hit_cnt), .hit_ts(hit_ts), .hit_rev(hit_rev),
        .lo_byte(lo_byte), .ax(ax), .bsel(bsel)
    );

    assign accept  = (state_q == ST_IDLE) && rd_req;
    assign frz_all = (state_q == ST_IDLE) && !rd_req && wr_req
                     && (int'(addr) == SNAP_ADDR);

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        assign frz[a] = frz_all || (accept && lo_byte && (ax == AXW'(a)));

        enc_axis_hold #(.CNT_W(CNT_W), .TS_W(TS_W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (enc_ld[a]),
            .cnt_in  (enc_cnt[a*CNT_W +: CNT_W]),
            .ts_in   (enc_ts[a*TS_W +: TS_W]),
            .frz     (frz[a]),
            .hold_lo (hold_lo[a]),
            .snap_cnt(snap_cnt[a]),
            .snap_ts (snap_ts[a])
        );
    end

    // byte selection
    always_comb begin
        rd_byte = 8'h00;
        if (hit_cnt) begin
            if (lo_byte) begin
                rd_byte = hold_lo[ax];
            end else begin
                for (int k = 1; k < CNT_BYTES; k++) begin
                    if (bsel == BSW'(k)) rd_byte = snap_cnt[ax][k*8 +: 8];
                end
            end
        end else if (hit_ts) begin
            for (int k = 0; k < TS_BYTES; k++) begin
                if (bsel == BSW'(k)) rd_byte = snap_ts[ax][k*8 +: 8];
            end
        end else if (hit_rev) begin
            rd_byte = REV;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_req) state_d = ST_RDATA;  // accept
            ST_RDATA: state_d = ST_IDLE;               // retire
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= 8'h00;
        else if (accept) data_q <= rd_byte;
    end

    // outputs
    always_comb begin
        rd_vld = 1'b0;
        rdata  = 8'h00;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RDATA: begin
                rd_vld = 1'b1;
                rdata  = data_q;
            end
        endcase
    end
endmodule

// File: rtl/enc_snap_rd_chk.sv
module enc_snap_rd_chk #(
    parameter int         ADDR_W   = 5,
    parameter int         GAP_LO   = 12,
    parameter int         GAP_HI   = 15,
    parameter int         REV_ADDR = 31,
    parameter logic [7:0] REV      = 8'h02
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              rd_vld
);
    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |=> !rd_vld);

    p_vld_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_vld) |=> rd_vld);

    p_no_spurious_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_vld);

    p_rev_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_vld && int'(addr) == REV_ADDR) |=> (rdata == REV));

    p_gap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_vld && int'(addr) >= GAP_LO && int'(addr) <= GAP_HI)
        |=> (rdata == 8'h00));
endmodule

bind enc_snap_rd enc_snap_rd_chk #(
    .ADDR_W  (ADDR_W),
    .GAP_LO  (CNT_BASE + NAX*CNT_BYTES),
    .GAP_HI  (TS_BASE - 1),
    .REV_ADDR(REV_ADDR),
    .REV     (REV)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .addr  (addr),
    .rdata (rdata),
    .rd_vld(rd_vld)
);

// File: tb/enc_snap_rd_tb.sv
module enc_snap_rd_tb;
    localparam int NAX = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    enc_ld = '0;
    logic [95:0]   enc_cnt = '0;
    logic [63:0]   enc_ts = '0;
    logic          rd_req = 1'b0;
    logic          wr_req = 1'b0;
    logic [4:0]    addr = '0;
    logic [7:0]    rdata;
    logic          rd_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    enc_snap_rd u_dut (
        .clk(clk), .rst_n(rst_n), .enc_ld(enc_ld), .enc_cnt(enc_cnt),
        .enc_ts(enc_ts), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
        .rdata(rdata), .rd_vld(rd_vld)
    );

    // behavioural reference
    logic [23:0] m_hc [NAX];
    logic [15:0] m_ht [NAX];
    logic [23:0] m_sc [NAX];
    logic [15:0] m_st [NAX];
    logic        m_vld;
    logic [7:0]  m_data;

    function automatic logic [7:0] m_byte(input int ad);
        if (ad < 12) begin
            if (ad % 3 == 0) return m_hc[ad/3][7:0];
            return 8'(m_sc[ad/3] >> (8*(ad%3)));
        end
        if (ad >= 16 && ad < 24) return 8'(m_st[(ad-16)/2] >> (8*(ad%2)));
        if (ad == 31) return 8'h02;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vld = 1'b0; m_data = 8'h00;
            for (int a = 0; a < NAX; a++) begin
                m_hc[a] = '0; m_ht[a] = '0; m_sc[a] = '0; m_st[a] = '0;
            end
        end else begin
            if (!m_vld && rd_req) begin
                m_data = m_byte(int'(addr));
                if (int'(addr) < 12 && int'(addr) % 3 == 0) begin
                    m_sc[int'(addr)/3] = m_hc[int'(addr)/3];
                    m_st[int'(addr)/3] = m_ht[int'(addr)/3];
                end
                m_vld = 1'b1;
            end else begin
                if (!m_vld && wr_req && int'(addr) == 30) begin
                    for (int a = 0; a < NAX; a++) begin
                        m_sc[a] = m_hc[a]; m_st[a] = m_ht[a];
                    end
                end
                m_vld = 1'b0;
                m_data = 8'h00;
            end
            for (int a = 0; a < NAX; a++) begin
                if (enc_ld[a]) begin
                    m_hc[a] = enc_cnt[a*24 +: 24];
                    m_ht[a] = enc_ts[a*16 +: 16];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference compared every clock (R2 timing and all read data)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_vld == m_vld, "R2 model vld", {7'b0, rd_vld}, {7'b0, m_vld});
            chk(rdata == m_data, "R5 model data", rdata, m_data);
        end
    end

    task automatic rd(input int ad, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_req = 1'b1; addr = 5'(ad);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_vld && rdata == exp, tag, rdata, exp);
    endtask

    task automatic wr(input int ad);
        @(negedge clk);
        wr_req = 1'b1; addr = 5'(ad);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic load(input logic [7:0] base);
        @(negedge clk);
        for (int a = 0; a < NAX; a++) begin
            enc_cnt[a*24 +: 24] = {8'(base + 8'h00 + 8'(a)), 8'(base + 8'h10 + 8'(a)),
                                   8'(base + 8'h20 + 8'(a))};
            enc_ts[a*16 +: 16]  = {8'(base + 8'h30 + 8'(a)), 8'(base + 8'h40 + 8'(a))};
        end
        enc_ld = '1;
        @(negedge clk);
        enc_ld = '0;
        enc_cnt = '0;
        enc_ts = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_vld == 1'b0 && rdata == 8'h00, "R1 reset outputs", rdata, 8'h00);
        rst_n = 1'b1;
        rd(1, 8'h00, "R1 snapshot zero");

        // set A: cnt={A0+a,B0+a,C0+a}, ts={D0+a,E0+a}
        load(8'hA0);
        rd(0, 8'hC0, "R4 low byte from hold");
        rd(1, 8'hB0, "R5 count byte1");
        rd(2, 8'hA0, "R5 count byte2");
        rd(16, 8'hE0, "R3 ts byte0 paired");
        rd(17, 8'hD0, "R3 ts byte1 paired");

        // set B: cnt={10+a,20+a,30+a}, ts={40+a,50+a}
        load(8'h10);
        rd(1, 8'hB0, "R5 stale until refresh");
        rd(17, 8'hD0, "R5 ts stale until refresh");
        rd(0, 8'h30, "R4 refresh low byte");
        rd(1, 8'h20, "R4 refreshed byte1");
        rd(16, 8'h50, "R4 refreshed ts");

        rd(4, 8'h00, "R10 other axis untouched");
        rd(18, 8'h00, "R10 other axis ts untouched");

        wr(30);
        rd(4, 8'h21, "R7 freeze all axis1");
        rd(19, 8'h41, "R7 freeze all axis1 ts");
        rd(11, 8'h13, "R7 freeze all axis3");

        load(8'hA0);
        wr(5);
        rd(4, 8'h21, "R8 write ignored");
        rd(10, 8'h23, "R8 write ignored axis3");

        rd(31, 8'h02, "R6 revision");
        for (int g = 12; g < 16; g++) rd(g, 8'h00, "R9 gap low");
        for (int g = 24; g < 31; g++) rd(g, 8'h00, "R9 gap high");

        // request held over two cycles: second dropped
        @(negedge clk);
        rd_req = 1'b1; addr = 5'd31;
        @(negedge clk);
        chk(rd_vld && rdata == 8'h02, "R2 first accepted", rdata, 8'h02);
        @(negedge clk);
        rd_req = 1'b0;
        chk(!rd_vld && rdata == 8'h00, "R2 second dropped", rdata, 8'h00);

        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            rd_req = 1'b1; addr = 5'(s);
            @(negedge clk);
            rd_req = 1'b0;
        end
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule